// File: doc/BRIEF.md
# Load/Store Address and Data Formatter

This block is the memory-access stage of a 32-bit register-based processor. For each decoded load or store it computes the effective address from a base value and a scaled, signed-direction offset. It also computes the value to write back to the base register, which depends on the indexing mode. It drives one word-wide little-endian data bus with per-byte enables.

For stores, the block places the store data on the correct byte lanes. For loads, it selects the addressed byte or halfword from the returned word and zero- or sign-extends it to 32 bits.

A request is accepted in the cycle `req_valid` is high, and the bus signals are driven combinationally in that cycle. The memory answers at the next clock edge. A one-cycle `done` pulse then presents the load result, the base write-back value and its enable. Misaligned halfword and word requests raise a fault, and no memory access or write-back takes place.

Top module: `ldst_unit`

## Requirements
- R1: `acc_size` encodes 0 = byte, 1 = halfword, 2 = word; the value 3 (no size qualifier) behaves exactly as a word access.
- R2: An unsigned byte or halfword load returns the datum in the low bits of `load_data` with all upper bits zero.
- R3: A signed byte or halfword load returns the datum sign-extended to 32 bits as two's complement.
- R4: With `idx_mode` = 0 (offset), `mem_addr` is base combined with offset, and `wb_en` stays low.
- R5: With `idx_mode` = 1 (pre-indexed), `mem_addr` is base combined with offset. When `wb_req` is high, that same sum appears on `wb_value` with `wb_en` high. When `wb_req` is low, `wb_en` stays low.
- R6: With `idx_mode` = 2 (post-indexed), `mem_addr` is the unmodified base, and base combined with offset appears on `wb_value` with `wb_en` high.
- R7: The offset is shifted left by `off_shift` bits before it is combined, giving base + (offset << n).
- R8: `off_up` = 1 adds the scaled offset and `off_up` = 0 subtracts it; the result wraps modulo 2^32.
- R9: Store lanes follow little-endian order. A byte store replicates the byte on all four lanes and enables only lane `addr[1:0]`. A halfword store replicates the halfword on both halves and enables lanes {1,0} when `addr[1]` = 0 or lanes {3,2} when `addr[1]` = 1. A word store enables all four lanes.
- R10: A load selects byte lane `addr[1:0]`, or the halfword at `addr[1]`, from `mem_rdata` before extension; a word load returns `mem_rdata` unchanged.
- R11: A halfword request with `addr[0]` = 1, or a word request with `addr[1:0]` ≠ 0, raises `align_fault` with `done`. It keeps `mem_en` low, keeps `wb_en` low and returns `load_data` = 0.
- R12: `done` is high exactly in the cycle after each cycle in which `req_valid` was high, and `wb_en`, `align_fault` and a nonzero `load_data` occur only while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| is_store | input | 1 | 1 = store, 0 = load |
| acc_size | input | 2 | Access size code |
| ld_signed | input | 1 | Sign-extend a byte/halfword load |
| idx_mode | input | 2 | 0 offset, 1 pre-indexed, 2 post-indexed |
| wb_req | input | 1 | Write back base in pre-indexed mode |
| off_up | input | 1 | 1 add offset, 0 subtract |
| base_val | input | 32 | Base register value |
| off_val | input | 32 | Immediate or register offset |
| off_shift | input | 5 | Left shift applied to the offset |
| st_data | input | 32 | Store data, right-aligned |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Access address |
| mem_be | output | 4 | Byte enables, bit i = lane i |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_rdata | input | 32 | Word returned one cycle after a read strobe |
| done | output | 1 | Completion pulse |
| load_data | output | 32 | Formatted load result |
| wb_value | output | 32 | Updated base value |
| wb_en | output | 1 | Base write-back enable |
| align_fault | output | 1 | Misaligned request flagged |

## Verification
The hardest case to reach is a misaligned request that also asks for write-back. It must leave no trace in memory and no base update, even though every address and data input looks legal. The stimulus issues a halfword store at an odd address in pre-indexed mode with `wb_req` set. It then reads back the surrounding word through a normal aligned load, which shows that the memory still holds its earlier contents. Subtraction wrap-around is reached by post-indexing from a base smaller than the scaled offset.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_DFLT = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      IX_OFFSET = 2'd0,
      IX_PRE    = 2'd1,
      IX_POST   = 2'd2,
      IX_RSVD   = 2'd3
   } idx_mode_e;
endpackage

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen #(
   parameter int AW  = 32,
   parameter int SHW = 5
) (
   input  logic [AW-1:0]  base_val,
   input  logic [AW-1:0]  off_val,
   input  logic [SHW-1:0] off_shift,
   input  logic           off_up,
   input  logic [1:0]     idx_mode,
   output logic [AW-1:0]  acc_addr,
   output logic [AW-1:0]  upd_addr
);
   import ldst_pkg::*;

   logic [AW-1:0] scaled;
   logic [AW-1:0] sum;

   always_comb begin
      scaled   = off_val << off_shift;
      sum      = off_up ? (base_val + scaled) : (base_val - scaled);
      upd_addr = sum;
      acc_addr = (idx_mode_e'(idx_mode) == IX_POST) ? base_val : sum;
   end
endmodule

// File: rtl/ldst_store_fmt.sv
module ldst_store_fmt #(
   parameter int LANES = 4
) (
   input  logic [1:0]         acc_size,
   input  logic [1:0]         lane,
   input  logic [8*LANES-1:0] st_data,
   output logic [8*LANES-1:0] lane_data,
   output logic [LANES-1:0]   lane_be,
   output logic               misaligned
);
   import ldst_pkg::*;

   logic is_byte, is_half;

   always_comb begin
      is_byte    = (acc_size_e'(acc_size) == SZ_BYTE);
      is_half    = (acc_size_e'(acc_size) == SZ_HALF);
      misaligned = is_half ? lane[0] : (!is_byte && (lane != 2'd0));
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam logic [1:0] LI = 2'(i);
      always_comb begin
         if (is_byte) begin
            lane_data[8*i +: 8] = st_data[7:0];
            lane_be[i]          = (lane == LI);
         end else if (is_half) begin
            lane_data[8*i +: 8] = st_data[8*(i%2) +: 8];
            lane_be[i]          = (lane[1] == LI[1]);
         end else begin
            lane_data[8*i +: 8] = st_data[8*i +: 8];
            lane_be[i]          = 1'b1;
         end
      end
   end
endmodule

// File: rtl/ldst_load_fmt.sv
module ldst_load_fmt #(
   parameter int DW = 32
) (
   input  logic [1:0]    acc_size,
   input  logic          ld_signed,
   input  logic [1:0]    lane,
   input  logic [DW-1:0] rdata,
   output logic [DW-1:0] result
);
   import ldst_pkg::*;

   logic [7:0]  sel_b;
   logic [15:0] sel_h;

   always_comb begin
      sel_b = rdata[8*lane +: 8];
      sel_h = lane[1] ? rdata[31:16] : rdata[15:0];
      unique case (acc_size_e'(acc_size))
         SZ_BYTE: result = ld_signed ? {{(DW-8){sel_b[7]}}, sel_b}
                                     : {{(DW-8){1'b0}}, sel_b};
         SZ_HALF: result = ld_signed ? {{(DW-16){sel_h[15]}}, sel_h}
                                     : {{(DW-16){1'b0}}, sel_h};
         default: result = rdata;
      endcase
   end
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit #(
   parameter int AW  = 32,
   parameter int DW  = 32,
   parameter int SHW = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   input  logic           is_store,
   input  logic [1:0]     acc_size,
   input  logic           ld_signed,
   input  logic [1:0]     idx_mode,
   input  logic           wb_req,
   input  logic           off_up,
   input  logic [AW-1:0]  base_val,
   input  logic [AW-1:0]  off_val,
   input  logic [SHW-1:0] off_shift,
   input  logic [DW-1:0]  st_data,
   output logic           mem_en,
   output logic           mem_we,
   output logic [AW-1:0]  mem_addr,
   output logic [DW/8-1:0] mem_be,
   output logic [DW-1:0]  mem_wdata,
   input  logic [DW-1:0]  mem_rdata,
   output logic           done,
   output logic [DW-1:0]  load_data,
   output logic [AW-1:0]  wb_value,
   output logic           wb_en,
   output logic           align_fault
);
   import ldst_pkg::*;

   localparam int LANES = DW / 8;

   if (DW != 32) begin : g_chk_dw
      $error("ldst_unit: DW must be 32");
   end
   if (AW < 2) begin : g_chk_aw
      $error("ldst_unit: AW must be at least 2");
   end
   if ((1 << SHW) > AW) begin : g_chk_shw
      $error("ldst_unit: SHW too wide for AW");
   end

   logic [AW-1:0] acc_addr, upd_addr;
   logic          misaligned;
   logic          wb_want;

   ldst_addr_gen #(.AW(AW), .SHW(SHW)) u_addr (
      .base_val (base_val),
      .off_val  (off_val),
      .off_shift(off_shift),
      .off_up   (off_up),
      .idx_mode (idx_mode),
      .acc_addr (acc_addr),
      .upd_addr (upd_addr)
   );

   ldst_store_fmt #(.LANES(LANES)) u_st (
      .acc_size  (acc_size),
      .lane      (acc_addr[1:0]),
      .st_data   (st_data),
      .lane_data (mem_wdata),
      .lane_be   (mem_be),
      .misaligned(misaligned)
   );

   always_comb begin
      mem_en   = req_valid && !misaligned;
      mem_we   = mem_en && is_store;
      mem_addr = acc_addr;
      unique case (idx_mode_e'(idx_mode))
         IX_PRE:  wb_want = wb_req;
         IX_POST: wb_want = 1'b1;
         default: wb_want = 1'b0;
      endcase
   end

   logic       done_q, fault_q, wb_en_q, load_q, sign_q;
   logic [1:0] lane_q, size_q;
   logic [AW-1:0] wb_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         wb_en_q <= 1'b0;
         load_q  <= 1'b0;
         sign_q  <= 1'b0;
         lane_q  <= 2'd0;
         size_q  <= 2'd0;
         wb_q    <= '0;
      end else begin
         done_q  <= req_valid;
         fault_q <= req_valid && misaligned;
         wb_en_q <= req_valid && !misaligned && wb_want;
         load_q  <= req_valid && !misaligned && !is_store;
         if (req_valid) begin
            sign_q <= ld_signed;
            lane_q <= acc_addr[1:0];
            size_q <= acc_size;
            wb_q   <= upd_addr;
         end
      end
   end

   logic [DW-1:0] fmt_data;

   ldst_load_fmt #(.DW(DW)) u_ld (
      .acc_size (size_q),
      .ld_signed(sign_q),
      .lane     (lane_q),
      .rdata    (mem_rdata),
      .result   (fmt_data)
   );

   always_comb begin
      done        = done_q;
      align_fault = fault_q;
      wb_en       = wb_en_q;
      wb_value    = wb_q;
      load_data   = load_q ? fmt_data : '0;
   end

   // Checks on the combined behaviour of the sub-blocks
   assert_fault_blocks_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ((acc_size == 2'd1 && acc_addr[0]) ||
                     (acc_size[1] && acc_addr[1:0] != 2'd0))) |-> !mem_en);

   assert_done_follows_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> done);

   assert_no_done_without_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !done);

   assert_wb_only_with_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> done);

   assert_fault_no_wb_R11: assert property (@(posedge clk) disable iff (!rst_n)
      align_fault |-> !wb_en && load_data == '0);

   assert_offset_no_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && idx_mode == 2'd0) |=> !wb_en);

   assert_byte_one_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && acc_size == 2'd0) |-> $countones(mem_be) == 1);

   assert_half_two_lanes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && acc_size == 2'd1) |-> $countones(mem_be) == 2);

   assert_unsigned_zero_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && load_q && !sign_q && size_q == 2'd0) |-> load_data[DW-1:8] == '0);
endmodule

// File: tb/ldst_unit_test.sv
module ldst_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, is_store = 1'b0, ld_signed = 1'b0;
   logic        wb_req = 1'b0, off_up = 1'b1;
   logic [1:0]  acc_size = 2'd2, idx_mode = 2'd0;
   logic [31:0] base_val = '0, off_val = '0, st_data = '0;
   logic [4:0]  off_shift = '0;
   logic        mem_en, mem_we, done, wb_en, align_fault;
   logic [31:0] mem_addr, mem_wdata, load_data, wb_value;
   logic [3:0]  mem_be;
   logic [31:0] mem_rdata = '0;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   ldst_unit uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .is_store(is_store),
      .acc_size(acc_size), .ld_signed(ld_signed), .idx_mode(idx_mode),
      .wb_req(wb_req), .off_up(off_up), .base_val(base_val), .off_val(off_val),
      .off_shift(off_shift), .st_data(st_data), .mem_en(mem_en), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .done(done), .load_data(load_data),
      .wb_value(wb_value), .wb_en(wb_en), .align_fault(align_fault)
   );

   logic [31:0] mem [16];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) mem[i] <= '0;
      end else if (mem_en) begin
         if (mem_we) begin
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) mem[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
         end else begin
            mem_rdata <= mem[mem_addr[5:2]];
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   logic [31:0] bus_addr, bus_wdata;
   logic [3:0]  bus_be;
   logic        bus_en;

   // Issue one request; bus sampled mid-cycle, results sampled one cycle later.
   task automatic op(input logic st, input logic [1:0] sz, input logic sg,
                     input logic [1:0] md, input logic wr, input logic up,
                     input logic [31:0] b, input logic [31:0] o, input logic [4:0] sh,
                     input logic [31:0] d);
      @(negedge clk);
      is_store = st; acc_size = sz; ld_signed = sg; idx_mode = md; wb_req = wr;
      off_up = up; base_val = b; off_val = o; off_shift = sh; st_data = d;
      req_valid = 1'b1;
      #1;
      bus_addr = mem_addr; bus_wdata = mem_wdata; bus_be = mem_be; bus_en = mem_en;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic t_reset;
      chk("R12 reset done", {31'd0, done}, 32'd0);
      chk("R12 reset wb_en", {31'd0, wb_en}, 32'd0);
      chk("R11 reset fault", {31'd0, align_fault}, 32'd0);
   endtask

   task automatic t_offset_word;
      op(1, 2'd2, 0, 2'd0, 1, 1, 32'h1C, 32'h4, 5'd0, 32'h81F27344);
      chk("R4 offset addr", bus_addr, 32'h20);
      chk("R9 word be", {28'd0, bus_be}, 32'hF);
      chk("R4 offset no wb", {31'd0, wb_en}, 32'd0);
      chk("R12 done pulse", {31'd0, done}, 32'd1);
      @(negedge clk);
      chk("R12 done drops", {31'd0, done}, 32'd0);
   endtask

   task automatic t_load_ext;
      op(0, 2'd0, 0, 2'd0, 0, 1, 32'h20, 0, 0, 0);
      chk("R2 ubyte lane0", load_data, 32'h44);
      op(0, 2'd0, 0, 2'd0, 0, 1, 32'h23, 0, 0, 0);
      chk("R10 ubyte lane3", load_data, 32'h81);
      op(0, 2'd0, 1, 2'd0, 0, 1, 32'h23, 0, 0, 0);
      chk("R3 sbyte neg", load_data, 32'hFFFFFF81);
      op(0, 2'd0, 1, 2'd0, 0, 1, 32'h20, 0, 0, 0);
      chk("R3 sbyte pos", load_data, 32'h44);
      op(0, 2'd1, 0, 2'd0, 0, 1, 32'h22, 0, 0, 0);
      chk("R2 uhalf upper", load_data, 32'h81F2);
      op(0, 2'd1, 1, 2'd0, 0, 1, 32'h22, 0, 0, 0);
      chk("R3 shalf neg", load_data, 32'hFFFF81F2);
      op(0, 2'd1, 1, 2'd0, 0, 1, 32'h20, 0, 0, 0);
      chk("R10 shalf lower", load_data, 32'h7344);
      op(0, 2'd3, 0, 2'd0, 0, 1, 32'h20, 0, 0, 0);
      chk("R1 default size word", load_data, 32'h81F27344);
   endtask

   task automatic t_pre_post;
      op(1, 2'd2, 0, 2'd1, 1, 1, 32'h30, 32'h8, 0, 32'hCAFEF00D);
      chk("R5 pre addr", bus_addr, 32'h38);
      chk("R5 pre wb value", wb_value, 32'h38);
      chk("R5 pre wb_en", {31'd0, wb_en}, 32'd1);
      op(0, 2'd2, 0, 2'd1, 0, 1, 32'h30, 32'h8, 0, 0);
      chk("R5 pre no wb_req", {31'd0, wb_en}, 32'd0);
      op(0, 2'd2, 0, 2'd2, 0, 1, 32'h38, 32'h4, 0, 0);
      chk("R6 post addr", bus_addr, 32'h38);
      chk("R6 post data", load_data, 32'hCAFEF00D);
      chk("R6 post wb value", wb_value, 32'h3C);
      chk("R6 post wb_en", {31'd0, wb_en}, 32'd1);
   endtask

   task automatic t_shift_sub;
      op(0, 2'd2, 0, 2'd1, 1, 1, 32'h10, 32'h3, 5'd2, 0);
      chk("R7 scaled addr", bus_addr, 32'h1C);
      chk("R7 scaled wb", wb_value, 32'h1C);
      op(0, 2'd0, 0, 2'd2, 0, 0, 32'h4, 32'h8, 5'd0, 0);
      chk("R8 sub post addr", bus_addr, 32'h4);
      chk("R8 sub wrap wb", wb_value, 32'hFFFFFFFC);
      op(0, 2'd2, 0, 2'd0, 0, 0, 32'h40, 32'h2, 5'd3, 0);
      chk("R8 sub scaled addr", bus_addr, 32'h30);
   endtask

   task automatic t_store_lanes;
      op(1, 2'd0, 0, 2'd0, 0, 1, 32'h11, 0, 0, 32'h123456A5);
      chk("R9 byte be", {28'd0, bus_be}, 32'h2);
      chk("R9 byte replicate", bus_wdata, 32'hA5A5A5A5);
      op(1, 2'd1, 0, 2'd0, 0, 1, 32'h16, 0, 0, 32'h5555BEEF);
      chk("R9 half be", {28'd0, bus_be}, 32'hC);
      chk("R9 half replicate", bus_wdata, 32'hBEEFBEEF);
      op(0, 2'd2, 0, 2'd0, 0, 1, 32'h10, 0, 0, 0);
      chk("R9 byte placed", load_data, 32'h0000A500);
      op(0, 2'd2, 0, 2'd0, 0, 1, 32'h14, 0, 0, 0);
      chk("R9 half placed", load_data, 32'hBEEF0000);
   endtask

   task automatic t_fault;
      op(1, 2'd1, 0, 2'd1, 1, 1, 32'h24, 32'h1, 0, 32'hFFFFFFFF);
      chk("R11 half mem_en low", {31'd0, bus_en}, 32'd0);
      chk("R11 half fault", {31'd0, align_fault}, 32'd1);
      chk("R11 half no wb", {31'd0, wb_en}, 32'd0);
      op(0, 2'd2, 0, 2'd0, 0, 1, 32'h24, 0, 0, 0);
      chk("R11 memory untouched", load_data, 32'h0);
      op(0, 2'd3, 0, 2'd2, 0, 1, 32'h22, 32'h4, 0, 0);
      chk("R11 word fault", {31'd0, align_fault}, 32'd1);
      chk("R11 word data zero", load_data, 32'h0);
      chk("R11 post no wb", {31'd0, wb_en}, 32'd0);
      op(0, 2'd0, 0, 2'd0, 0, 1, 32'h23, 0, 0, 0);
      chk("R11 byte never faults", {31'd0, align_fault}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_offset_word();
      t_load_ext();
      t_pre_post();
      t_shift_sub();
      t_store_lanes();
      t_fault();
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule